// File: doc/BRIEF.md
# Multi-Mode Multiply-Accumulate Unit

This block pairs one 16x16-bit multiplier with a 40-bit accumulator register. Each cycle with `valid_i` high carries one operation: clear the accumulator, load it with the product, add the product to it, or subtract the product from it. The result is registered and appears on `acc_o` after the next rising clock edge.

A three-bit mode chooses how the operands are read (signed or unsigned), whether the product gets the one-bit left shift that fractional signed formats need, and which range the result is clamped to. There are three ranges: signed 40-bit, unsigned 40-bit, and signed 32-bit held inside the 40-bit register. A separate mixed flag multiplies a signed first operand by an unsigned second operand. A sticky overflow output records any clamp until the next clear operation or reset.

Top module: `mmac_core`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `acc_o` to 0 and `ovf_o` to 0.
- R2: When `valid_i` is high, `op_i` selects the operation, and the result is visible one clock edge later. 0 clears the accumulator and the overflow flag. 1 loads the extended product. 2 adds the extended product to the accumulator. 3 subtracts the extended product from the accumulator.
- R3: When `valid_i` is low, `acc_o` and `ovf_o` keep their values whatever `op_i`, `mode_i` and the operands carry.
- R4: Mode 0 reads both operands as signed 1.15 values. The 32-bit product is shifted left by one bit and sign-extended to 40 bits. For example, 0x8000 times 0x8000 loads 0x00_8000_0000 without overflow.
- R5: Modes 0 and 3 clamp every load, add and subtract result to the range 0x80_0000_0000 to 0x7F_FFFF_FFFF.
- R6: Mode 1 (unsigned fraction) and mode 2 (unsigned integer) read both operands as unsigned. The product is not shifted and is zero-extended. The accumulator is also read as unsigned, and results are clamped to the range 0x00_0000_0000 to 0xFF_FFFF_FFFF.
- R7: Mode 3 reads both operands as signed integers. The product is not shifted and is sign-extended to 40 bits.
- R8: Mode 4 forms the product as in mode 0, then clamps the result to the range 0xFF_8000_0000 to 0x00_7FFF_FFFF. For example, 0x8000 times 0x8000 loads 0x00_7FFF_FFFF and sets the overflow flag.
- R9: With `mixed_i` high, operand A is signed and operand B is unsigned. The product is not shifted and is sign-extended. The accumulator interpretation and the clamp range follow `mode_i`.
- R10: `ovf_o` becomes 1 whenever a load, add or subtract result is clamped. It stays at 1 until a clear operation or a reset.
- R11: Mode codes 5, 6 and 7 behave exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Operation: 0 clear, 1 load, 2 add, 3 subtract |
| mode_i | input | 3 | 0 signed fraction, 1 unsigned fraction, 2 unsigned integer, 3 signed integer, 4 signed fraction with 32-bit clamp |
| mixed_i | input | 1 | Signed A times unsigned B, with no shift |
| opa_i | input | 16 | Operand A |
| opb_i | input | 16 | Operand B |
| acc_o | output | 40 | Accumulator value |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Clamping and the sticky flag update can fall in the same cycle. An add or subtract that crosses a range limit must both pin the value at the limit and raise `ovf_o` on that edge. A clear that arrives while the flag is set must drop the flag and the value together.

The bench provokes the first case by running long chains of identical adds and subtracts, so that one step lands exactly across each limit of each range. It provokes the second case by clearing after a clamp. Every cycle is judged against an independent arithmetic model, so the exact cycle of the crossing, the pinned value and the flag are all compared.

// File: rtl/mmac_pkg.sv
package mmac_pkg;

   typedef enum logic [1:0] {
      OP_CLR  = 2'd0,
      OP_LOAD = 2'd1,
      OP_ADD  = 2'd2,
      OP_SUB  = 2'd3
   } mac_op_e;

   localparam logic [2:0] MD_SFRAC   = 3'd0;
   localparam logic [2:0] MD_UFRAC   = 3'd1;
   localparam logic [2:0] MD_UINT    = 3'd2;
   localparam logic [2:0] MD_SINT    = 3'd3;
   localparam logic [2:0] MD_SFRAC32 = 3'd4;

   function automatic logic md_unsigned(input logic [2:0] md);
      return (md == MD_UFRAC) || (md == MD_UINT);
   endfunction

   function automatic logic md_narrow(input logic [2:0] md);
      return md == MD_SFRAC32;
   endfunction

   // Signed fractional formats need the one-bit shift; reserved codes act as mode 0.
   function automatic logic md_frac_signed(input logic [2:0] md);
      return !md_unsigned(md) && (md != MD_SINT);
   endfunction

endpackage

// File: rtl/mmac_mult.sv
module mmac_mult
   import mmac_pkg::*;
#(
   parameter int OP_W     = 16,
   parameter int WIDE_W   = 42,
   parameter bit MIXED_EN = 1'b1
) (
   input  logic [OP_W-1:0]          opa_i,
   input  logic [OP_W-1:0]          opb_i,
   input  logic [2:0]               mode_i,
   input  logic                     mixed_i,
   output logic signed [WIDE_W-1:0] ext_o
);
   localparam int PROD_W = 2 * (OP_W + 1);

   if (WIDE_W <= PROD_W) begin : g_bad_wide
      $error("mmac_mult: WIDE_W must exceed the product width");
   end

   logic mix;
   if (MIXED_EN) begin : g_mix
      assign mix = mixed_i;
   end else begin : g_nomix
      assign mix = 1'b0;
   end

   logic                     a_sgn, b_sgn, do_shift;
   logic signed [OP_W:0]     a_x, b_x;
   logic signed [PROD_W-1:0] prod, prod_sh;

   always_comb begin
      a_sgn    = mix || !md_unsigned(mode_i);
      b_sgn    = !mix && !md_unsigned(mode_i);
      do_shift = !mix && md_frac_signed(mode_i);
      a_x      = {a_sgn & opa_i[OP_W-1], opa_i};
      b_x      = {b_sgn & opb_i[OP_W-1], opb_i};
      prod     = PROD_W'(a_x) * PROD_W'(b_x);
      prod_sh  = do_shift ? (prod <<< 1) : prod;
      ext_o    = {{(WIDE_W-PROD_W){prod_sh[PROD_W-1]}}, prod_sh};
   end
endmodule

// File: rtl/mmac_sat.sv
module mmac_sat
   import mmac_pkg::*;
#(
   parameter int ACC_W    = 40,
   parameter int NARROW_W = 32,
   parameter int WIDE_W   = 42
) (
   input  logic signed [WIDE_W-1:0] val_i,
   input  logic [2:0]               mode_i,
   output logic [ACC_W-1:0]         res_o,
   output logic                     clip_o
);
   if (NARROW_W < 2 || NARROW_W >= ACC_W) begin : g_bad_narrow
      $error("mmac_sat: NARROW_W must lie between 2 and ACC_W-1");
   end
   if (WIDE_W < ACC_W + 2) begin : g_bad_wide
      $error("mmac_sat: WIDE_W must be at least ACC_W+2");
   end

   localparam logic signed [WIDE_W-1:0] S_HI = {{(WIDE_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
   localparam logic signed [WIDE_W-1:0] S_LO = {{(WIDE_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};
   localparam logic signed [WIDE_W-1:0] U_HI = {{(WIDE_W-ACC_W){1'b0}}, {ACC_W{1'b1}}};
   localparam logic signed [WIDE_W-1:0] U_LO = '0;
   localparam logic signed [WIDE_W-1:0] N_HI = {{(WIDE_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
   localparam logic signed [WIDE_W-1:0] N_LO = {{(WIDE_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

   logic signed [WIDE_W-1:0] hi, lo, pick;

   always_comb begin
      if (md_unsigned(mode_i)) begin
         hi = U_HI;
         lo = U_LO;
      end else if (md_narrow(mode_i)) begin
         hi = N_HI;
         lo = N_LO;
      end else begin
         hi = S_HI;
         lo = S_LO;
      end
      clip_o = 1'b1;
      if (val_i > hi)      pick = hi;
      else if (val_i < lo) pick = lo;
      else begin
         pick   = val_i;
         clip_o = 1'b0;
      end
      res_o = pick[ACC_W-1:0];
   end
endmodule

// File: rtl/mmac_core.sv
module mmac_core
   import mmac_pkg::*;
#(
   parameter int OP_W     = 16,
   parameter int ACC_W    = 40,
   parameter int NARROW_W = 32,
   parameter bit MIXED_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             valid_i,
   input  logic [1:0]       op_i,
   input  logic [2:0]       mode_i,
   input  logic             mixed_i,
   input  logic [OP_W-1:0]  opa_i,
   input  logic [OP_W-1:0]  opb_i,
   output logic [ACC_W-1:0] acc_o,
   output logic             ovf_o
);
   localparam int WIDE_W = ACC_W + 2;

   if (ACC_W <= 2 * OP_W) begin : g_bad_acc
      $error("mmac_core: ACC_W must exceed twice OP_W");
   end

   logic signed [WIDE_W-1:0] prod_ext, acc_ext, sum;
   logic [ACC_W-1:0]         sat_res;
   logic                     sat_clip;
   logic [ACC_W-1:0]         acc_q;
   logic                     ovf_q;

   mmac_mult #(.OP_W(OP_W), .WIDE_W(WIDE_W), .MIXED_EN(MIXED_EN)) mult_i (
      .opa_i  (opa_i),
      .opb_i  (opb_i),
      .mode_i (mode_i),
      .mixed_i(mixed_i),
      .ext_o  (prod_ext)
   );

   always_comb begin
      acc_ext = md_unsigned(mode_i) ? {2'b00, acc_q} : {{2{acc_q[ACC_W-1]}}, acc_q};
      unique case (mac_op_e'(op_i))
         OP_LOAD: sum = prod_ext;
         OP_ADD:  sum = acc_ext + prod_ext;
         OP_SUB:  sum = acc_ext - prod_ext;
         default: sum = '0;
      endcase
   end

   mmac_sat #(.ACC_W(ACC_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) sat_i (
      .val_i (sum),
      .mode_i(mode_i),
      .res_o (sat_res),
      .clip_o(sat_clip)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
      end else if (valid_i) begin
         if (op_i == OP_CLR) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
         end else begin
            acc_q <= sat_res;
            ovf_q <= ovf_q | sat_clip;
         end
      end
   end

   assign acc_o = acc_q;
   assign ovf_o = ovf_q;

   a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
      ovf_q && !(valid_i && op_i == OP_CLR) |=> ovf_q);

   a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> $stable(acc_q) && $stable(ovf_q));

   a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
      valid_i && op_i == OP_CLR |=> acc_q == '0 && !ovf_q);

   a_r8_narrow_range: assert property (@(posedge clk) disable iff (rst)
      valid_i && op_i != OP_CLR && mode_i == MD_SFRAC32
      |=> (acc_q[ACC_W-1:NARROW_W-1] == '0) || (acc_q[ACC_W-1:NARROW_W-1] == '1));

   a_r6_uint_load_fits: assert property (@(posedge clk) disable iff (rst)
      valid_i && op_i == OP_LOAD && mode_i == MD_UINT && !mixed_i |=> ovf_q == $past(ovf_q));
endmodule

// File: tb/mmac_core_tb.sv
`timescale 1ns/1ps
module mmac_core_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid_i = 1'b0;
   logic [1:0]  op_i = 2'd0;
   logic [2:0]  mode_i = 3'd0;
   logic        mixed_i = 1'b0;
   logic [15:0] opa_i = '0;
   logic [15:0] opb_i = '0;
   logic [39:0] acc_o;
   logic        ovf_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      logic [39:0] acc;
      logic        ovf;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   logic [39:0] m_acc = '0;
   logic        m_ovf = 1'b0;

   always #2 clk = ~clk;

   mmac_core dut_i (
      .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .mode_i(mode_i),
      .mixed_i(mixed_i), .opa_i(opa_i), .opb_i(opb_i), .acc_o(acc_o), .ovf_o(ovf_o)
   );

   task automatic compare(input logic [39:0] ea, input logic eo, input string tag);
      checks++;
      if (acc_o !== ea || ovf_o !== eo) begin
         failures++;
         $display("FAIL %s: acc=%h ovf=%b expected acc=%h ovf=%b", tag, acc_o, ovf_o, ea, eo);
      end
   endtask

   // Monitor: one item per driven cycle, compared just after the edge that applies it.
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         exp_t it;
         it = sb_q.pop_front();
         compare(it.acc, it.ovf, it.tag);
      end
   end

   // Reference arithmetic written from the requirements.
   task automatic model(input bit v, input logic [1:0] op, input logic [2:0] md,
                        input bit mx, input logic [15:0] a, input logic [15:0] b);
      bit     uns, nar, sa, sb, sh;
      longint av, bv, p, accv, r, hi, lo;
      if (!v) return;
      if (op == 2'd0) begin
         m_acc = '0;
         m_ovf = 1'b0;
         return;
      end
      uns = (md == 3'd1) || (md == 3'd2);
      nar = (md == 3'd4);
      sa  = mx || !uns;
      sb  = !mx && !uns;
      sh  = !mx && !uns && (md != 3'd3);
      av  = sa ? longint'($signed(a)) : longint'(a);
      bv  = sb ? longint'($signed(b)) : longint'(b);
      p   = av * bv;
      if (sh) p = p * 2;
      accv = uns ? longint'(m_acc) : longint'($signed(m_acc));
      if (op == 2'd1)      r = p;
      else if (op == 2'd2) r = accv + p;
      else                 r = accv - p;
      if (uns) begin
         lo = 0;
         hi = (longint'(1) <<< 40) - 1;
      end else if (nar) begin
         lo = -(longint'(1) <<< 31);
         hi = (longint'(1) <<< 31) - 1;
      end else begin
         lo = -(longint'(1) <<< 39);
         hi = (longint'(1) <<< 39) - 1;
      end
      if (r > hi) begin
         r = hi;
         m_ovf = 1'b1;
      end else if (r < lo) begin
         r = lo;
         m_ovf = 1'b1;
      end
      m_acc = r[39:0];
   endtask

   task automatic drive(input bit v, input logic [1:0] op, input logic [2:0] md,
                        input bit mx, input logic [15:0] a, input logic [15:0] b,
                        input string tag);
      exp_t it;
      @(negedge clk);
      valid_i = v;
      op_i    = op;
      mode_i  = md;
      mixed_i = mx;
      opa_i   = a;
      opb_i   = b;
      model(v, op, md, mx, a, b);
      it.acc = m_acc;
      it.ovf = m_ovf;
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst     = 1'b1;
      valid_i = 1'b0;
      repeat (3) @(negedge clk);
      rst   = 1'b0;
      m_acc = '0;
      m_ovf = 1'b0;
      compare(40'h0, 1'b0, "R1 reset state");
   endtask

   task automatic expect_now(input logic [39:0] ea, input logic eo, input string tag);
      @(negedge clk);
      valid_i = 1'b0;
      @(negedge clk);
      compare(ea, eo, tag);
   endtask

   initial begin
      do_reset();

      drive(1, 2'd1, 3'd0, 0, 16'h8000, 16'h8000, "R4 minus one squared");
      expect_now(40'h00_8000_0000, 1'b0, "R4 literal +1.0");
      drive(1, 2'd2, 3'd0, 0, 16'h4000, 16'h4000, "R2 add");
      drive(1, 2'd3, 3'd0, 0, 16'h7fff, 16'h7fff, "R2 subtract");
      drive(0, 2'd0, 3'd2, 1, 16'hffff, 16'hffff, "R3 idle ignores clear");
      drive(0, 2'd1, 3'd4, 0, 16'h8000, 16'h8000, "R3 idle ignores load");
      drive(1, 2'd0, 3'd0, 0, 16'h1234, 16'h5678, "R2 clear");

      drive(1, 2'd1, 3'd3, 0, 16'h7fff, 16'h7fff, "R7 signed int load");
      drive(1, 2'd1, 3'd3, 0, 16'hfffd, 16'h0007, "R7 signed int negative");
      for (int i = 0; i < 520; i++)
         drive(1, 2'd3, 3'd3, 0, 16'h8000, 16'h7fff, "R5 R7 climb to top");
      drive(1, 2'd2, 3'd3, 0, 16'hffff, 16'h0001, "R10 sticky after clamp");
      drive(1, 2'd0, 3'd0, 0, 16'h0, 16'h0, "R10 clear drops flag");

      for (int i = 0; i < 260; i++)
         drive(1, 2'd3, 3'd0, 0, 16'h7fff, 16'h7fff, "R5 descend to bottom");
      drive(1, 2'd0, 3'd0, 0, 16'h0, 16'h0, "R2 clear");

      drive(1, 2'd1, 3'd4, 0, 16'h8000, 16'h8000, "R8 narrow clamp top");
      expect_now(40'h00_7FFF_FFFF, 1'b1, "R8 literal top");
      drive(1, 2'd0, 3'd4, 0, 16'h0, 16'h0, "R2 clear");
      drive(1, 2'd1, 3'd4, 0, 16'h8000, 16'h7fff, "R8 narrow load negative");
      drive(1, 2'd3, 3'd4, 0, 16'h4000, 16'h4000, "R8 narrow clamp bottom");
      expect_now(40'hFF_8000_0000, 1'b1, "R8 literal bottom");
      drive(1, 2'd0, 3'd0, 0, 16'h0, 16'h0, "R2 clear");

      drive(1, 2'd1, 3'd1, 0, 16'hffff, 16'hffff, "R6 unsigned fraction load");
      expect_now(40'h00_FFFE_0001, 1'b0, "R6 literal zero extend");
      drive(1, 2'd3, 3'd1, 0, 16'hffff, 16'hffff, "R6 subtract to zero");
      drive(1, 2'd3, 3'd1, 0, 16'h0001, 16'h0001, "R6 clamp at zero");
      drive(1, 2'd0, 3'd2, 0, 16'h0, 16'h0, "R2 clear");
      drive(1, 2'd1, 3'd2, 0, 16'h1234, 16'h0010, "R6 unsigned int load");
      for (int i = 0; i < 260; i++)
         drive(1, 2'd2, 3'd2, 0, 16'hffff, 16'hffff, "R6 climb to unsigned top");
      drive(1, 2'd0, 3'd0, 0, 16'h0, 16'h0, "R2 clear");

      drive(1, 2'd1, 3'd0, 1, 16'hffff, 16'hffff, "R9 mixed fraction");
      expect_now(40'hFF_FFFF_0001, 1'b0, "R9 literal mixed");
      drive(1, 2'd2, 3'd3, 1, 16'h8000, 16'h8000, "R9 mixed integer add");
      drive(1, 2'd1, 3'd1, 1, 16'hffff, 16'h0002, "R9 mixed with unsigned clamp");
      drive(1, 2'd0, 3'd0, 0, 16'h0, 16'h0, "R2 clear");

      drive(1, 2'd1, 3'd5, 0, 16'h8000, 16'h8000, "R11 code 5 as mode 0");
      drive(1, 2'd2, 3'd7, 0, 16'hc000, 16'h4000, "R11 code 7 as mode 0");

      drive(1, 2'd1, 3'd3, 0, 16'h0100, 16'h0100, "R1 value before reset");
      @(negedge clk);
      valid_i = 1'b0;
      repeat (2) @(negedge clk);
      do_reset();

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule